// File: doc/BRIEF.md
# Programmable Interval Clock Timer

The block is a programmable interval timer attached to a simple register bus. Software loads a 16-bit preset into a write-only reload buffer, which at the same time loads the live counter. The counter then moves one step toward a zero crossing, down or up, on every pulse of a selected rate input while the run bit is set. Software can also advance it by one step with a self-clearing step bit in the control register.

When a count completes, the done flag is set. If done was still set from an earlier completion, the overrun flag is set as well. In one-shot mode the counter stays at zero and run drops. In auto-reload mode the counter takes the buffer value in the same step, so it never shows zero. Reading the control register returns both flags and clears them. An interrupt request is raised when done and interrupt enable are both set, and it is held until the request is acknowledged or done is cleared.

The fast and slow rate inputs are single-cycle pulses in the block's clock domain. The line and external inputs are asynchronous levels. They are synchronized, and only their rising edges count.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0 and irq_o is low.
- R2: Register select addr_i: 0 = control, 1 = reload buffer, 2 = counter, 3 reads 0. In the control register, bits 6 (interrupt enable), 4 (direction, 1 = up), 3 (mode, 1 = auto-reload), 2:1 (rate) and 0 (run) are read/write. Writes to bit 15 (overrun) and bit 7 (done) are ignored, and bit 5 (step) always reads 0.
- R3: Writing the reload buffer loads the counter with the same value. The buffer reads back as 0, and writes to the counter register leave it unchanged.
- R4: A control write with bit 5 set advances the counter by one in the direction given by bit 4 of that same write.
- R5: While run is set, each pulse of the selected rate input advances the counter once. The rate codes are 00 = fast tick, 01 = slow tick, 10 = line, 11 = external. Line and external count only on a rising edge, however long the level is held. Unselected inputs, and all inputs while run is clear, have no effect.
- R6: A count completes when the counter steps down from 1 or up from 0xFFFF. Completion sets done (bit 7).
- R7: In one-shot mode a completed count leaves the counter at 0 and clears run.
- R8: In auto-reload mode a completed count loads the counter from the reload buffer in the same step.
- R9: A completion while done is already set also sets overrun (bit 15).
- R10: A read of the control register returns done and overrun, and then clears both.
- R11: irq_o rises one cycle after interrupt enable and done both become set. This includes setting interrupt enable while done is already set.
- R12: irq_o, once raised, is held until irq_ack_i is seen or until done or interrupt enable is cleared. It is not raised again while the condition stays true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (read side effects) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| tick_fast_i | input | 1 | Fast rate pulse, one cycle |
| tick_slow_i | input | 1 | Slow rate pulse, one cycle |
| tick_line_i | input | 1 | Line frequency level, asynchronous |
| tick_ext_i | input | 1 | External rate level, asynchronous |
| irq_o | output | 1 | Interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge |

## Verification
The hardest state to reach from the ports is an overrun: a second completion has to arrive while done is still set. In auto-reload mode the counter never passes through zero, so it is hard to see when a completion has occurred. The bench reaches this state with step writes from a preset of 2 and no status read in between, then expects the counter to read 2 and both flags to be set. The interrupt re-raise case is reached in a similar way: done is left set, and interrupt enable is cleared and set again.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned DW = 16;

  typedef enum logic [1:0] {
    RATE_FAST = 2'd0,
    RATE_SLOW = 2'd1,
    RATE_LINE = 2'd2,
    RATE_EXT  = 2'd3
  } rate_e;

  typedef enum logic [1:0] {
    SEL_CTL = 2'd0,
    SEL_BUF = 2'd1,
    SEL_CNT = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int unsigned B_ERR  = 15;
  localparam int unsigned B_DONE = 7;
  localparam int unsigned B_IE   = 6;
  localparam int unsigned B_STEP = 5;
  localparam int unsigned B_UP   = 4;
  localparam int unsigned B_RPT  = 3;
  localparam int unsigned B_RATE = 1;
  localparam int unsigned B_RUN  = 0;
endpackage

// File: rtl/ptmr_tick_sel.sv
module ptmr_tick_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_fast_i,
  input  logic       tick_slow_i,
  input  logic       tick_line_i,
  input  logic       tick_ext_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  import ptmr_pkg::*;
  localparam int unsigned NA = 2;

  logic [NA-1:0] async_in;
  logic [NA-1:0] edge_w;
  assign async_in = {tick_ext_i, tick_line_i};

  for (genvar gi = 0; gi < NA; gi++) begin : g_sync
    logic [SYNC_STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[SYNC_STAGES-1:0], async_in[gi]};
    end
    assign edge_w[gi] = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    a_r5_edge_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_w[gi] |=> !edge_w[gi]) else $error("R5 edge pulse longer than one cycle");
  end

  always_comb begin
    unique case (rate_e'(rate_i))
      RATE_FAST: tick_o = tick_fast_i;
      RATE_SLOW: tick_o = tick_slow_i;
      RATE_LINE: tick_o = edge_w[0];
      default:   tick_o = edge_w[1];
    endcase
  end
endmodule

// File: rtl/ptmr_count_core.sv
module ptmr_count_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         buf_wr_i,
  input  logic [W-1:0] buf_data_i,
  input  logic         step_i,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         up_i,
  input  logic         rpt_i,
  input  logic         stat_rd_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o,
  output logic         err_o,
  output logic         complete_o
);
  logic [W-1:0] cnt_q, buf_q;
  logic         done_q, err_q;
  logic         count_en, at_end, complete;

  assign count_en = step_i | (run_i & tick_i);
  assign at_end   = up_i ? (cnt_q == {W{1'b1}}) : (cnt_q == W'(1));
  assign complete = count_en & ~buf_wr_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      buf_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (buf_wr_i) begin
        buf_q <= buf_data_i;
        cnt_q <= buf_data_i;
      end else if (complete) begin
        cnt_q <= rpt_i ? buf_q : '0;
      end else if (count_en) begin
        cnt_q <= up_i ? cnt_q + W'(1) : cnt_q - W'(1);
      end
      // completion outranks the clearing read
      if (complete)       done_q <= 1'b1;
      else if (stat_rd_i) done_q <= 1'b0;
      if (complete && done_q && !stat_rd_i) err_q <= 1'b1;
      else if (stat_rd_i)                   err_q <= 1'b0;
    end
  end

  assign cnt_o      = cnt_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign complete_o = complete;

  a_r3_buf_loads_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_i |=> cnt_q == $past(buf_data_i)) else $error("R3 load");
  a_r6_done_on_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete |=> done_q) else $error("R6 done");
  a_r7_single_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete && !rpt_i |=> cnt_q == '0) else $error("R7 zero");
  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete && rpt_i |=> cnt_q == $past(buf_q)) else $error("R8 reload");
  a_r9_err_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(done_q)) else $error("R9 overrun");
endmodule

// File: rtl/ptmr_irq.sv
module ptmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ie_i,
  input  logic done_i,
  input  logic ack_i,
  output logic irq_o
);
  logic cond, cond_q, irq_q;
  assign cond = ie_i & done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      if (!cond)        irq_q <= 1'b0;
      else if (!cond_q) irq_q <= 1'b1;
      else if (ack_i)   irq_q <= 1'b0;
    end
  end
  assign irq_o = irq_q;

  a_r11_irq_needs_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(ie_i && done_i)) else $error("R11 irq");
  a_r12_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && ack_i |=> !irq_q) else $error("R12 ack");
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer #(
  parameter int unsigned W           = ptmr_pkg::DW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   addr_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         tick_fast_i,
  input  logic         tick_slow_i,
  input  logic         tick_line_i,
  input  logic         tick_ext_i,
  output logic         irq_o,
  input  logic         irq_ack_i
);
  import ptmr_pkg::*;

  logic       ie_q, up_q, rpt_q, run_q;
  logic [1:0] rate_q;
  logic       ctl_wr, buf_wr, stat_rd, step, up_eff, rpt_eff;
  logic       tick, done, err, complete;
  logic [W-1:0] cnt;

  assign ctl_wr  = wr_i & (sel_e'(addr_i) == SEL_CTL);
  assign buf_wr  = wr_i & (sel_e'(addr_i) == SEL_BUF);
  assign stat_rd = rd_i & (sel_e'(addr_i) == SEL_CTL);
  assign step    = ctl_wr & wdata_i[B_STEP];
  assign up_eff  = ctl_wr ? wdata_i[B_UP]  : up_q;
  assign rpt_eff = ctl_wr ? wdata_i[B_RPT] : rpt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= 1'b0; up_q <= 1'b0; rpt_q <= 1'b0; run_q <= 1'b0; rate_q <= '0;
    end else begin
      if (ctl_wr) begin
        ie_q   <= wdata_i[B_IE];
        up_q   <= wdata_i[B_UP];
        rpt_q  <= wdata_i[B_RPT];
        rate_q <= wdata_i[B_RATE+:2];
        run_q  <= wdata_i[B_RUN];
      end
      if (complete && !rpt_eff) run_q <= 1'b0;
    end
  end

  ptmr_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_fast_i(tick_fast_i), .tick_slow_i(tick_slow_i),
    .tick_line_i(tick_line_i), .tick_ext_i(tick_ext_i),
    .rate_i(rate_q), .tick_o(tick)
  );

  ptmr_count_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .buf_wr_i(buf_wr), .buf_data_i(wdata_i),
    .step_i(step), .tick_i(tick), .run_i(run_q),
    .up_i(up_eff), .rpt_i(rpt_eff), .stat_rd_i(stat_rd),
    .cnt_o(cnt), .done_o(done), .err_o(err), .complete_o(complete)
  );

  ptmr_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .ie_i(ie_q), .done_i(done),
    .ack_i(irq_ack_i), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel_e'(addr_i))
      SEL_CTL: begin
        rdata_o[B_ERR]      = err;
        rdata_o[B_DONE]     = done;
        rdata_o[B_IE]       = ie_q;
        rdata_o[B_UP]       = up_q;
        rdata_o[B_RPT]      = rpt_q;
        rdata_o[B_RATE+:2]  = rate_q;
        rdata_o[B_RUN]      = run_q;
      end
      SEL_CNT: rdata_o = cnt;
      default: rdata_o = '0;
    endcase
  end

  a_r7_run_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete && !rpt_eff |=> !run_q) else $error("R7 run");
  a_r2_step_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_e'(addr_i) == SEL_CTL |-> !rdata_o[B_STEP]) else $error("R2 step bit");
endmodule

// File: tb/prog_interval_timer_bench.sv
module prog_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        t_fast = 0, t_slow = 0, t_line = 0, t_ext = 0;
  logic        irq, ack = 1'b0;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  prog_interval_timer u_prog_interval_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tick_fast_i(t_fast), .tick_slow_i(t_slow),
    .tick_line_i(t_line), .tick_ext_i(t_ext), .irq_o(irq), .irq_ack_i(ack)
  );

  localparam logic [1:0] A_CTL = 2'd0, A_BUF = 2'd1, A_CNT = 2'd2, A_NONE = 2'd3;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [1:0] a, logic [15:0] exp);
    logic [15:0] d;
    rreg(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic hold_high(ref logic sig);
    @(negedge clk); sig = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    expect_reg("R1 ctl", A_CTL, 16'h0000);
    expect_reg("R1 cnt", A_CNT, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_ctl_fields();
    wreg(A_CTL, 16'h80DF);
    expect_reg("R2 fields", A_CTL, 16'h005F);
    wreg(A_CTL, 16'h0000);
    expect_reg("R2 unused addr", A_NONE, 16'h0000);
  endtask

  task automatic t_buf();
    wreg(A_BUF, 16'hBEAF);
    expect_reg("R3 buf reads 0", A_BUF, 16'h0000);
    expect_reg("R3 cnt loaded", A_CNT, 16'hBEAF);
    wreg(A_CNT, 16'hDEAD);
    expect_reg("R3 cnt write ignored", A_CNT, 16'hBEAF);
  endtask

  task automatic t_step();
    wreg(A_BUF, 16'h0103);
    wreg(A_CTL, 16'h0020);
    expect_reg("R4 step down", A_CNT, 16'h0102);
    expect_reg("R4 step bit reads 0", A_CTL, 16'h0000);
    wreg(A_CTL, 16'h0030);
    expect_reg("R4 step up", A_CNT, 16'h0103);
  endtask

  task automatic t_single();
    wreg(A_CTL, 16'h0000);
    wreg(A_BUF, 16'h0002);
    wreg(A_CTL, 16'h0020);
    expect_reg("R6 not done yet", A_CTL, 16'h0000);
    wreg(A_CTL, 16'h0020);
    expect_reg("R7 cnt zero", A_CNT, 16'h0000);
    expect_reg("R6 done down", A_CTL, 16'h0080);
    expect_reg("R10 cleared", A_CTL, 16'h0000);
    wreg(A_BUF, 16'h0001);
    wreg(A_CTL, 16'h0021);
    expect_reg("R7 run cleared", A_CTL, 16'h0080);
    wreg(A_BUF, 16'hFFFF);
    wreg(A_CTL, 16'h0030);
    expect_reg("R6 up cnt", A_CNT, 16'h0000);
    expect_reg("R6 done up", A_CTL, 16'h0090);
  endtask

  task automatic t_repeat();
    wreg(A_BUF, 16'h0002);
    wreg(A_CTL, 16'h0028);
    expect_reg("R8 step", A_CNT, 16'h0001);
    wreg(A_CTL, 16'h0028);
    expect_reg("R8 reload", A_CNT, 16'h0002);
    expect_reg("R8 done", A_CTL, 16'h0088);
    expect_reg("R10 clear rpt", A_CTL, 16'h0008);
  endtask

  task automatic t_overrun();
    wreg(A_BUF, 16'h0002);
    repeat (4) wreg(A_CTL, 16'h0028);
    expect_reg("R9 cnt", A_CNT, 16'h0002);
    expect_reg("R9 err", A_CTL, 16'h8088);
    expect_reg("R10 err cleared", A_CTL, 16'h0008);
  endtask

  task automatic t_rates();
    wreg(A_CTL, 16'h0000);
    wreg(A_BUF, 16'd10);
    wreg(A_CTL, 16'h0001);
    pulse(t_fast);
    expect_reg("R5 fast", A_CNT, 16'd9);
    pulse(t_slow);
    expect_reg("R5 unselected slow", A_CNT, 16'd9);
    wreg(A_CTL, 16'h0003);
    pulse(t_slow);
    expect_reg("R5 slow", A_CNT, 16'd8);
    wreg(A_CTL, 16'h0005);
    hold_high(t_line);
    expect_reg("R5 line edge", A_CNT, 16'd7);
    repeat (6) @(negedge clk);
    expect_reg("R5 line level held", A_CNT, 16'd7);
    t_line = 1'b0;
    hold_high(t_ext);
    expect_reg("R5 unselected ext", A_CNT, 16'd7);
    t_ext = 1'b0;
    repeat (6) @(negedge clk);
    wreg(A_CTL, 16'h0007);
    hold_high(t_ext);
    expect_reg("R5 ext edge", A_CNT, 16'd6);
    t_ext = 1'b0;
    wreg(A_CTL, 16'h0000);
    pulse(t_fast);
    expect_reg("R5 run off", A_CNT, 16'd6);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wreg(A_CTL, 16'h0040);
    wreg(A_BUF, 16'h0001);
    wreg(A_CTL, 16'h0060);
    @(negedge clk);
    chk("R11 irq on done", {15'd0, irq}, 16'h1);
    repeat (3) @(negedge clk);
    chk("R12 irq held", {15'd0, irq}, 16'h1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 ack drops, no re-raise", {15'd0, irq}, 16'h0);
    wreg(A_CTL, 16'h0000);
    wreg(A_CTL, 16'h0040);
    @(negedge clk);
    chk("R11 ie set with done", {15'd0, irq}, 16'h1);
    rreg(A_CTL, d);
    chk("R10 ctl with ie", d, 16'h00C0);
    @(negedge clk);
    chk("R12 done cleared drops irq", {15'd0, irq}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl_fields();
    t_buf();
    t_step();
    t_single();
    t_repeat();
    t_overrun();
    t_rates();
    t_irq();
    summary();
    $finish;
  end
endmodule